// File: doc/BRIEF.md
# Sequential Line Prefetch Controller

This block sits beside a level one instruction cache. It holds a small, fully associative buffer of prefetched lines, each with its tag and data. Every fetch looks the buffer up in the same cycle as the cache. When the fetch misses in both, the cache sends its own demand request to level two. The controller then plans a short run of requests for the lines that follow the missing line.

Those requests go out one at a time, and only in cycles when the cache leaves the level two port free. The first line of the run is the one after the miss, and the addresses rise from there. The run never passes the last line of the page that holds the miss. A later miss throws away any requests that are still waiting and starts a new run. A response that comes back is always written into the buffer, even when its request was cancelled after it issued. Misses never flush the buffer.

Replacement is least recently used. A build option, when set, also copies each line that hits in the buffer to the cache through a registered fill output.

Top module: `nl_prefetch_ctrl`

## Requirements
- R1: When `fetch_valid` is high and a valid buffer entry holds `fetch_line`, `pb_hit` is high in the same cycle and `pb_data` carries that entry's data. Otherwise `pb_hit` is low.
- R2: A demand miss is a cycle with `fetch_valid` high, `ic_hit` low and `pb_hit` low. It loads a run that starts at `fetch_line`+1. The run holds up to `QDEPTH` lines, issued one per accepted request in ascending line order.
- R3: `pf_req_valid` is low in every cycle where `l2_busy` is high and in every cycle that has a demand miss.
- R4: A demand miss discards every request of the previous run that has not yet been accepted. The next request that issues is the line after the new miss.
- R5: A response goes first to the lowest-numbered empty entry. When no entry is empty, it replaces the least recently used entry. A buffer hit and a written response each make their entry the most recent. When both occur in one cycle, the hit is applied first.
- R6: Page size is `PAGE_BYTES` and line size is `LINE_BYTES`. No request names a line outside the page of the miss that started the run. A miss on the page's last line issues no request.
- R7: A request is accepted in a cycle where `pf_req_valid` and `pf_req_ready` are both high. After that, `pf_req_valid` stays low until the next response arrives. Every response is written, even when its run was cancelled, and entries are never invalidated by misses.
- R8: A response whose line is already in the buffer overwrites that entry's data and refreshes its recency. It never takes a second entry.
- R9: With `COPY_EN`=1, a buffer hit while `ic_hit` is low raises `fill_valid` in the next cycle, with that line and its data on `fill_line` and `fill_data`. With `COPY_EN`=0, `fill_valid` is never high.
- R10: While `rst` is high and in the cycle after it: the buffer is empty, `pf_req_valid` is low and `fill_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A fetch is looked up this cycle |
| fetch_line | input | ADDR_W-log2(LINE_BYTES) | Line address of the fetch |
| ic_hit | input | 1 | The level one cache hit this fetch |
| pb_hit | output | 1 | The buffer holds the fetched line |
| pb_data | output | LINE_BYTES*8 | Data of the hitting entry, zero when there is no hit |
| l2_busy | input | 1 | The cache uses the level two port this cycle |
| pf_req_valid | output | 1 | A prefetch request is presented |
| pf_req_ready | input | 1 | Level two takes the request this cycle |
| pf_req_line | output | ADDR_W-log2(LINE_BYTES) | Line address of the request |
| pf_rsp_valid | input | 1 | A prefetch response arrives |
| pf_rsp_line | input | ADDR_W-log2(LINE_BYTES) | Line address of the response |
| pf_rsp_data | input | LINE_BYTES*8 | Line data of the response |
| fill_valid | output | 1 | Copy of a buffer hit offered to the cache |
| fill_line | output | ADDR_W-log2(LINE_BYTES) | Line address of the copy |
| fill_data | output | LINE_BYTES*8 | Data of the copy |

## Verification
The hardest case to reach from the ports is a response that arrives after its run has already been cancelled by a new miss. The same is true when that response carries a line the buffer already holds, at a moment when the buffer is full, so that the dedup rule and the recency order both decide which entry changes. Directed sequences produce a miss, let exactly one request issue, and then miss elsewhere. They also repeat a run so that its lines come back a second time. A long pseudo-random phase then draws fetches from a pool of 40 lines that straddles a page boundary. Because this pool is larger than the buffer, it forces eviction while ready, busy and response latency vary. The reference model compares every output in every cycle.

// File: rtl/nlp_pkg.sv
package nlp_pkg;

    // How a fetch resolved in the lookup cycle.
    typedef enum logic [1:0] {
        FK_NONE   = 2'd0,
        FK_CACHE  = 2'd1,
        FK_BUFFER = 2'd2,
        FK_MISS   = 2'd3
    } fetch_kind_t;

    // Number of lines a run may take, given the offset of the missing line
    // inside its page, the lines per page and the run depth.
    function automatic int unsigned run_length(int unsigned offset,
                                               int unsigned lines_per_page,
                                               int unsigned depth);
        int unsigned room;
        room = lines_per_page - 1 - offset;
        return (room < depth) ? room : depth;
    endfunction

endpackage

// File: rtl/nlp_lookup.sv
module nlp_lookup #(
    parameter int ENTRIES = 16,
    parameter int LA_W    = 27,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               ent_v [ENTRIES],
    input  logic [LA_W-1:0]    ent_t [ENTRIES],
    input  logic [LA_W-1:0]    probe,
    output logic               hit,
    output logic [IDX_W-1:0]   idx,
    output logic [ENTRIES-1:0] match
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = ent_v[g] && (ent_t[g] == probe);
    end

    assign hit = |match;

    always_comb begin
        idx = '0;
        for (int j = ENTRIES - 1; j >= 0; j--) begin
            if (match[j]) idx = IDX_W'(j);
        end
    end
endmodule

// File: rtl/nlp_lru.sv
module nlp_lru #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ent_v [ENTRIES],
    input  logic             hit_touch,
    input  logic [IDX_W-1:0] hit_idx,
    input  logic             fill_touch,
    input  logic [IDX_W-1:0] fill_idx,
    output logic [IDX_W-1:0] victim
);
    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    // rank 0 is most recent, ENTRIES-1 is least recent
    logic [IDX_W-1:0] rank_q [ENTRIES];
    logic [IDX_W-1:0] rank_h [ENTRIES];
    logic [IDX_W-1:0] rank_f [ENTRIES];
    logic [ENTRIES-1:0] oldest_mask;

    always_comb begin
        for (int j = 0; j < ENTRIES; j++) begin
            if (!hit_touch)                       rank_h[j] = rank_q[j];
            else if (IDX_W'(j) == hit_idx)        rank_h[j] = '0;
            else if (rank_q[j] < rank_q[hit_idx]) rank_h[j] = rank_q[j] + 1'b1;
            else                                  rank_h[j] = rank_q[j];
        end
    end

    always_comb begin
        for (int j = 0; j < ENTRIES; j++) begin
            if (!fill_touch)                        rank_f[j] = rank_h[j];
            else if (IDX_W'(j) == fill_idx)         rank_f[j] = '0;
            else if (rank_h[j] < rank_h[fill_idx])  rank_f[j] = rank_h[j] + 1'b1;
            else                                    rank_f[j] = rank_h[j];
        end
    end

    always_comb begin
        victim = '0;
        for (int j = 0; j < ENTRIES; j++) begin
            if (rank_h[j] == OLDEST) victim = IDX_W'(j);
        end
        for (int j = ENTRIES - 1; j >= 0; j--) begin
            if (!ent_v[j]) victim = IDX_W'(j);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < ENTRIES; j++) rank_q[j] <= IDX_W'(j);
        end else begin
            for (int j = 0; j < ENTRIES; j++) rank_q[j] <= rank_f[j];
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_old
        assign oldest_mask[g] = (rank_q[g] == OLDEST);
    end

    // R5: the recency order stays a permutation with exactly one oldest entry
    a_r5_single_oldest: assert property (@(posedge clk) disable iff (rst)
        $countones(oldest_mask) == 1);
endmodule

// File: rtl/nlp_queue.sv
module nlp_queue
    import nlp_pkg::*;
#(
    parameter int LA_W   = 27,
    parameter int PG_W   = 7,
    parameter int QDEPTH = 4,
    parameter int CNT_W  = $clog2(QDEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            miss,
    input  logic [LA_W-1:0] miss_line,
    input  logic            l2_busy,
    input  logic            req_ready,
    input  logic            rsp_valid,
    output logic            req_valid,
    output logic [LA_W-1:0] req_line
);
    localparam int unsigned LPP = 1 << PG_W;

    logic [LA_W-1:0]      next_q;
    logic [CNT_W-1:0]     left_q;
    logic                 busy_q;
    logic [LA_W-PG_W-1:0] page_q;
    logic                 accept;

    assign req_valid = (left_q != '0) && !l2_busy && !busy_q && !miss;
    assign req_line  = next_q;
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            next_q <= '0;
            left_q <= '0;
            busy_q <= 1'b0;
            page_q <= '0;
        end else begin
            if (rsp_valid) busy_q <= 1'b0;
            if (accept) begin
                busy_q <= 1'b1;
                next_q <= next_q + 1'b1;
                left_q <= left_q - 1'b1;
            end
            if (miss) begin
                next_q <= miss_line + 1'b1;
                left_q <= CNT_W'(run_length(int'(miss_line[PG_W-1:0]), LPP, QDEPTH));
                page_q <= miss_line[LA_W-1:PG_W];
            end
        end
    end

    // R6: every request stays inside the page of the miss that started it
    a_r6_same_page: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_line[LA_W-1:PG_W] == page_q));

    // R4: after a miss the first request offered is the following line
    a_r4_restart: assert property (@(posedge clk) disable iff (rst)
        miss |=> (!req_valid || req_line == $past(miss_line) + 1'b1));
endmodule

// File: rtl/nl_prefetch_ctrl.sv
module nl_prefetch_ctrl
    import nlp_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int PB_LINES   = 16,
    parameter int PAGE_BYTES = 4096,
    parameter int QDEPTH     = 4,
    parameter bit COPY_EN    = 1'b1,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LA_W      = ADDR_W - OFF_W,
    localparam int DATA_W    = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_valid,
    input  logic [LA_W-1:0]   fetch_line,
    input  logic              ic_hit,
    output logic              pb_hit,
    output logic [DATA_W-1:0] pb_data,
    input  logic              l2_busy,
    output logic              pf_req_valid,
    input  logic              pf_req_ready,
    output logic [LA_W-1:0]   pf_req_line,
    input  logic              pf_rsp_valid,
    input  logic [LA_W-1:0]   pf_rsp_line,
    input  logic [DATA_W-1:0] pf_rsp_data,
    output logic              fill_valid,
    output logic [LA_W-1:0]   fill_line,
    output logic [DATA_W-1:0] fill_data
);
    localparam int PG_W  = $clog2(PAGE_BYTES / LINE_BYTES);
    localparam int IDX_W = $clog2(PB_LINES);

    logic              ent_v [PB_LINES];
    logic [LA_W-1:0]   ent_t [PB_LINES];
    logic [DATA_W-1:0] ent_d [PB_LINES];

    logic                lk_hit, rs_hit;
    logic [IDX_W-1:0]    lk_idx, rs_idx, victim, wr_idx;
    logic [PB_LINES-1:0] lk_match, rs_match;
    fetch_kind_t         kind;
    logic                demand_miss;

    nlp_lookup #(.ENTRIES(PB_LINES), .LA_W(LA_W)) u_fetch_lookup (
        .ent_v(ent_v), .ent_t(ent_t), .probe(fetch_line),
        .hit(lk_hit), .idx(lk_idx), .match(lk_match));

    nlp_lookup #(.ENTRIES(PB_LINES), .LA_W(LA_W)) u_fill_lookup (
        .ent_v(ent_v), .ent_t(ent_t), .probe(pf_rsp_line),
        .hit(rs_hit), .idx(rs_idx), .match(rs_match));

    always_comb begin
        if (!fetch_valid)  kind = FK_NONE;
        else if (ic_hit)   kind = FK_CACHE;
        else if (lk_hit)   kind = FK_BUFFER;
        else               kind = FK_MISS;
    end

    assign pb_hit      = fetch_valid && lk_hit;
    assign pb_data     = pb_hit ? ent_d[lk_idx] : '0;
    assign demand_miss = (kind == FK_MISS);
    assign wr_idx      = rs_hit ? rs_idx : victim;

    nlp_lru #(.ENTRIES(PB_LINES)) u_lru (
        .clk(clk), .rst(rst), .ent_v(ent_v),
        .hit_touch(pb_hit), .hit_idx(lk_idx),
        .fill_touch(pf_rsp_valid), .fill_idx(wr_idx),
        .victim(victim));

    nlp_queue #(.LA_W(LA_W), .PG_W(PG_W), .QDEPTH(QDEPTH)) u_queue (
        .clk(clk), .rst(rst),
        .miss(demand_miss), .miss_line(fetch_line),
        .l2_busy(l2_busy), .req_ready(pf_req_ready), .rsp_valid(pf_rsp_valid),
        .req_valid(pf_req_valid), .req_line(pf_req_line));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < PB_LINES; j++) begin
                ent_v[j] <= 1'b0;
                ent_t[j] <= '0;
                ent_d[j] <= '0;
            end
        end else if (pf_rsp_valid) begin
            ent_v[wr_idx] <= 1'b1;
            ent_t[wr_idx] <= pf_rsp_line;
            ent_d[wr_idx] <= pf_rsp_data;
        end
    end

    if (COPY_EN) begin : g_copy
        always_ff @(posedge clk) begin
            if (rst) begin
                fill_valid <= 1'b0;
                fill_line  <= '0;
                fill_data  <= '0;
            end else begin
                fill_valid <= (kind == FK_BUFFER);
                fill_line  <= fetch_line;
                fill_data  <= pb_data;
            end
        end
    end else begin : g_nocopy
        assign fill_valid = 1'b0;
        assign fill_line  = '0;
        assign fill_data  = '0;
    end

    // R3: the level two port is left to the cache whenever it is busy
    a_r3_busy_yields: assert property (@(posedge clk) disable iff (rst)
        l2_busy |-> !pf_req_valid);

    // R7: nothing new is offered the cycle after an accepted request
    a_r7_one_in_flight: assert property (@(posedge clk) disable iff (rst)
        (pf_req_valid && pf_req_ready) |=> !pf_req_valid);

    // R8: no two valid entries ever hold the same line
    a_r8_unique_tags: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match) && $onehot0(rs_match));

    // R9: a copy is only offered right after a buffer hit
    a_r9_copy_follows_hit: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> $past(pb_hit));
endmodule

// File: tb/nl_prefetch_ctrl_tb.sv
`timescale 1ns/1ps
module nl_prefetch_ctrl_tb;
    localparam int LA_W = 27;
    localparam int DW   = 256;
    localparam int NE   = 16;
    localparam int LPP  = 128;
    localparam int QD   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fetch_valid = 1'b0, ic_hit = 1'b0, l2_busy = 1'b0;
    logic pf_req_ready = 1'b0, pf_rsp_valid = 1'b0;
    logic [LA_W-1:0] fetch_line = '0, pf_rsp_line = '0;
    logic [DW-1:0]   pf_rsp_data = '0;
    logic pb_hit, pf_req_valid, fill_valid;
    logic [DW-1:0] pb_data, fill_data;
    logic [LA_W-1:0] pf_req_line, fill_line;
    logic nc_pb_hit, nc_req_valid, nc_fill_valid;
    logic [DW-1:0] nc_pb_data, nc_fill_data;
    logic [LA_W-1:0] nc_req_line, nc_fill_line;

    always #2.5 clk = ~clk;

    nl_prefetch_ctrl u_dut (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_line(fetch_line),
        .ic_hit(ic_hit), .pb_hit(pb_hit), .pb_data(pb_data), .l2_busy(l2_busy),
        .pf_req_valid(pf_req_valid), .pf_req_ready(pf_req_ready), .pf_req_line(pf_req_line),
        .pf_rsp_valid(pf_rsp_valid), .pf_rsp_line(pf_rsp_line), .pf_rsp_data(pf_rsp_data),
        .fill_valid(fill_valid), .fill_line(fill_line), .fill_data(fill_data));

    nl_prefetch_ctrl #(.COPY_EN(1'b0)) u_nocopy (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_line(fetch_line),
        .ic_hit(ic_hit), .pb_hit(nc_pb_hit), .pb_data(nc_pb_data), .l2_busy(l2_busy),
        .pf_req_valid(nc_req_valid), .pf_req_ready(pf_req_ready), .pf_req_line(nc_req_line),
        .pf_rsp_valid(pf_rsp_valid), .pf_rsp_line(pf_rsp_line), .pf_rsp_data(pf_rsp_data),
        .fill_valid(nc_fill_valid), .fill_line(nc_fill_line), .fill_data(nc_fill_data));

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // reference model state
    bit mv [NE];
    int mt [NE];
    logic [DW-1:0] md [NE];
    int ord [$];
    int nxt = 0, rem = 0;
    bit outst = 0;
    bit pend = 0;
    int pline = 0, pcnt = 0, gen = 0;
    bit efv = 0;
    int efl = 0;
    logic [DW-1:0] efd = '0;
    int fixed_lat = 2;
    bit rand_lat = 0;
    logic [31:0] lf = 32'h1234_5678;

    function automatic logic [DW-1:0] dfun(int line, int g);
        logic [31:0] w;
        w = (32'(line) * 32'h9E37_79B1) ^ (32'(g) << 8);
        return {8{w}};
    endfunction

    function automatic logic [31:0] rnd();
        lf ^= lf << 13;
        lf ^= lf >> 17;
        lf ^= lf << 5;
        return lf;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic touch(input int i);
        for (int k = 0; k < ord.size(); k++) begin
            if (ord[k] == i) begin
                ord.delete(k);
                break;
            end
        end
        ord.push_front(i);
    endtask

    task automatic cyc(input bit fv, input int fl, input bit ich, input bit bz, input bit rd);
        int hi, widx, room;
        bit eh, miss, erv, hs, rsp;
        logic [DW-1:0] ed;
        @(negedge clk);
        fetch_valid  = fv;
        fetch_line   = LA_W'(fl);
        ic_hit       = ich;
        l2_busy      = bz;
        pf_req_ready = rd;
        rsp = 0;
        pf_rsp_valid = 0;
        if (pend) begin
            if (pcnt <= 1) begin
                rsp = 1;
                pend = 0;
                gen++;
                pf_rsp_valid = 1;
                pf_rsp_line  = LA_W'(pline);
                pf_rsp_data  = dfun(pline, gen);
            end else pcnt--;
        end
        #1;
        hi = -1;
        for (int i = 0; i < NE; i++) if (fv && mv[i] && mt[i] == fl) hi = i;
        eh = (hi >= 0);
        ed = eh ? md[hi] : '0;
        miss = fv && !ich && !eh;
        erv = (rem > 0) && !bz && !outst && !miss;
        chk(pb_hit == eh, "R1 R5 R7 R8 pb_hit", DW'(pb_hit), DW'(eh));
        if (eh) chk(pb_data == ed, "R1 R8 pb_data", pb_data, ed);
        chk(nc_pb_hit == eh, "R1 pb_hit no-copy build", DW'(nc_pb_hit), DW'(eh));
        chk(pf_req_valid == erv, "R3 R7 pf_req_valid", DW'(pf_req_valid), DW'(erv));
        if (erv) chk(pf_req_line == LA_W'(nxt), "R2 R4 R6 pf_req_line",
                     DW'(pf_req_line), DW'(nxt));
        chk(fill_valid == efv, "R9 fill_valid", DW'(fill_valid), DW'(efv));
        if (efv) begin
            chk(fill_line == LA_W'(efl), "R9 fill_line", DW'(fill_line), DW'(efl));
            chk(fill_data == efd, "R9 fill_data", fill_data, efd);
        end
        chk(nc_fill_valid == 1'b0, "R9 fill_valid no-copy build", DW'(nc_fill_valid), '0);
        // model update, in the order of the requirements
        if (eh) touch(hi);
        if (rsp) begin
            widx = -1;
            for (int i = 0; i < NE; i++) if (mv[i] && mt[i] == pline) widx = i;
            if (widx < 0) begin
                for (int i = NE - 1; i >= 0; i--) if (!mv[i]) widx = i;
                if (widx < 0) widx = ord[$];
            end
            mv[widx] = 1;
            mt[widx] = pline;
            md[widx] = dfun(pline, gen);
            touch(widx);
            outst = 0;
        end
        hs = erv && rd;
        if (hs) begin
            outst = 1;
            pend  = 1;
            pline = nxt;
            pcnt  = rand_lat ? 1 + int'(rnd() % 4) : fixed_lat;
            nxt++;
            rem--;
        end
        if (miss) begin
            nxt  = fl + 1;
            room = LPP - 1 - (fl % LPP);
            rem  = (room < QD) ? room : QD;
        end
        efv = eh && !ich;
        efl = fl;
        efd = ed;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NE; i++) begin
            mv[i] = 0;
            mt[i] = 0;
            md[i] = '0;
            ord.push_back(i);
        end
        fetch_valid = 1;
        fetch_line  = LA_W'(5);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pb_hit == 1'b0, "R10 empty buffer", DW'(pb_hit), '0);
        chk(pf_req_valid == 1'b0, "R10 no request", DW'(pf_req_valid), '0);
        chk(fill_valid == 1'b0, "R10 no fill", DW'(fill_valid), '0);
        rst = 0;
        fetch_valid = 0;
        // first cycle after reset is compared by the model, R10 included
        idle(1);
        // R2: plain run after a miss
        cyc(1, 'h100, 0, 0, 1);
        idle(14);
        // R1 R9: hits on the prefetched lines, one with the cache also hitting
        for (int k = 1; k <= 4; k++) cyc(1, 'h100 + k, (k == 3), 0, 1);
        // R6: a miss two lines before the page end, with the port busy half the time
        cyc(1, 'h17D, 0, 0, 1);
        for (int k = 0; k < 12; k++) cyc(0, 0, 0, k[0], 1);
        // R6: a miss on the last line of a page
        cyc(1, 'h17F, 0, 0, 1);
        idle(5);
        // R4 R7: cancel after one request, then a late response still lands
        fixed_lat = 4;
        cyc(1, 'h300, 0, 0, 1);
        cyc(0, 0, 0, 0, 1);
        cyc(1, 'h400, 0, 0, 1);
        idle(20);
        cyc(1, 'h301, 0, 0, 1);
        // R3: ready withheld, then busy
        cyc(1, 'h500, 0, 0, 0);
        cyc(0, 0, 0, 1, 1);
        cyc(0, 0, 0, 0, 0);
        idle(20);
        // R8: repeat a run whose lines are already held
        fixed_lat = 1;
        cyc(1, 'h100, 0, 0, 1);
        idle(12);
        for (int k = 1; k <= 4; k++) cyc(1, 'h100 + k, 0, 0, 1);
        // R5: random traffic over a pool larger than the buffer, across a page edge
        rand_lat = 1;
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r;
            r = rnd();
            cyc(r[1:0] != 0, 'h1F0 + int'(r[15:8] % 40), r[3:2] == 0,
                r[5:4] == 0, r[7:6] != 0);
        end
        idle(10);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule